// File: doc/BRIEF.md
# Microcontroller Fetch, Decode and Skip Sequencer

This block is the front end of a small 4-bit controller whose instructions are one or two bytes long. Every clock cycle it reads one byte from a program ROM through a combinational read port (`romAddr` out, `romData` back in the same cycle) and then advances its program counter. When an opcode is a two-byte form, the byte that follows is taken as the operand in the next cycle. Once an instruction is complete, the sequencer presents it to the execute stage. It gives the opcode, the operand, a coarse handler class and a few qualifying flags, and it pulses `issueValid` for one cycle.

The execute stage can ask for the next instruction to be dropped by raising `skipReq` in the cycle after it sees an issue. A dropped instruction is still read in full, operand included, but it is never issued. The sequencer raises its own skip after a return-with-skip opcode. A build parameter selects the instruction family. In reduced families the extended opcodes are issued as no-operations and carry a warning flag. The sequencer also tracks the interrupt-enable state that the enable and disable opcodes change.

Top module: `mcuFetchSeq`

## Requirements
- R1: While `rstN` is low, `romAddr` is 0, `issueValid` is 0, `intEnable` is 1 and `stepCount` is 0.
- R2: The program counter advances by one each cycle after reset and wraps from 2^PC_W-1 to 0. The byte at `romAddr` is consumed in each cycle.
- R3: An opcode needs an operand byte when op[7:2]==6'h05, when op[7:4]==4'hA, or when op==8'h1E. One-byte instructions issue on the clock edge that consumes them. Two-byte instructions issue on the following edge, with the second byte on `issueArg`. One-byte instructions show `issueArg`=0.
- R4: A high `skipReq` sampled on a clock edge drops the instruction that completes on that edge, or the next one to complete if none does. A dropped instruction consumes all of its bytes and produces no `issueValid`.
- R5: Issuing opcode 8'h49 (return then skip) drops the next instruction. A dropped 8'h49 does not drop the next one.
- R6: `issueClass` encodes the high nibble: 8 gives 1 (zero-page pointer load), 9 gives 2 (load immediate), A gives 3 (jump or call), B gives 4 (zero-page call), C to F give 5 (jump in page).
- R7: For high nibbles 0 to 7, `issueClass` is 0 for 8'h00, 6 for 8'h48 and 7 for 8'h49. It is 8 (full-byte decode) for 8'h01 to 8'h1F, 8'h30 to 8'h33 and 8'h40 to 8'h4F. It is 9 (four-opcode group decode) for all other opcodes below 8'h80.
- R8: `issueAccLoad` is 1 for a load-immediate opcode only when the high nibble of the previously consumed opcode, dropped or not, is not 9. Before any fetch that previous opcode counts as 8'h00.
- R9: Opcodes 8'h1C and 8'h45 issue with `issueIllegal`=1 and `issueClass`=0.
- R10: With FAMILY not 0, the extended opcodes issue with `issueWarn`=1 and `issueClass`=0. These are 8'h01, 05, 14, 1A, 1D, 1F, 30, 31, 42, 43, 46, 47 and 4A to 4F, and the groups 20-23, 5C-5F, 6C-6F and 7C-7F. With FAMILY 0, `issueWarn` stays 0.
- R11: Issuing 8'h31 sets `intEnable` and issuing 8'h01 clears it, in both cases on the issue edge. Dropped or warned opcodes leave it unchanged.
- R12: `stepCount` counts clock cycles since reset, modulo 2^STEP_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| romAddr | output | PC_W | Program counter, ROM read address |
| romData | input | 8 | ROM byte at romAddr, same cycle |
| skipReq | input | 1 | Execute stage asks to drop the next instruction |
| issueValid | output | 1 | One-cycle pulse: an instruction is presented |
| issueOp | output | 8 | Issued opcode |
| issueArg | output | 8 | Operand byte, 0 for one-byte forms |
| issueClass | output | 4 | Handler class code |
| issueAccLoad | output | 1 | Load-immediate should write the accumulator |
| issueIllegal | output | 1 | Opcode is undefined |
| issueWarn | output | 1 | Extended opcode suppressed in this family |
| intEnable | output | 1 | Interrupt-enable state |
| stepCount | output | STEP_W | Cycles consumed since reset |

## Verification
The bench targets several corner cases:
- A two-byte opcode in the last ROM byte takes its operand from address 0. A counter that fails to wrap would read past the end of the ROM.
- Dropped two-byte instructions must still consume their operand. Otherwise the operand would be decoded as an opcode and every later issue cycle would shift.
- A dropped load-immediate followed by a second one checks that the dropped opcode still counts as the previous opcode. A dropped return-with-skip must not chain a second skip.
- A reduced-family instance runs the same program. Its interrupt-enable state must stay set and the extended opcodes must come out as flagged no-operations.

// File: rtl/mcuSeqPkg.sv
package mcuSeqPkg;

  localparam int FAMILY_FULL = 0;

  localparam logic [7:0] OP_RETSKIP = 8'h49;
  localparam logic [7:0] OP_RET     = 8'h48;
  localparam logic [7:0] OP_INT_ON  = 8'h31;
  localparam logic [7:0] OP_INT_OFF = 8'h01;

  typedef enum logic [3:0] {
    CLS_NOP     = 4'd0,
    CLS_LDZ     = 4'd1,
    CLS_LI      = 4'd2,
    CLS_JMPCAL  = 4'd3,
    CLS_CZP     = 4'd4,
    CLS_JCP     = 4'd5,
    CLS_RET     = 4'd6,
    CLS_RETSKIP = 4'd7,
    CLS_SINGLE  = 4'd8,
    CLS_GROUP   = 4'd9
  } opClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic argPhase;  // current byte is an operand
    logic opLoad;    // current byte is an opcode
    logic complete;  // instruction ends on this edge
    logic issue;     // complete and not dropped
  } seqStrobe_t;

  function automatic logic isTwoByte(input logic [7:0] op);
    return (op[7:2] == 6'h05) || (op[7:4] == 4'hA) || (op == 8'h1E);
  endfunction

  function automatic logic isIllegal(input logic [7:0] op);
    return (op == 8'h1C) || (op == 8'h45);
  endfunction

  function automatic logic isExtended(input logic [7:0] op);
    logic hit;
    case (op)
      8'h01, 8'h05, 8'h14, 8'h1A, 8'h1D, 8'h1F, 8'h30, 8'h31,
      8'h42, 8'h43, 8'h46, 8'h47, 8'h4A, 8'h4B, 8'h4C, 8'h4D,
      8'h4E, 8'h4F: hit = 1'b1;
      default: hit = (op[7:2] == 6'h08) || (op[7:2] == 6'h17) ||
                     (op[7:2] == 6'h1B) || (op[7:2] == 6'h1F);
    endcase
    return hit;
  endfunction

  function automatic opClass_t baseClass(input logic [7:0] op);
    opClass_t c;
    case (op[7:4])
      4'h8: c = CLS_LDZ;
      4'h9: c = CLS_LI;
      4'hA: c = CLS_JMPCAL;
      4'hB: c = CLS_CZP;
      4'hC, 4'hD, 4'hE, 4'hF: c = CLS_JCP;
      default: begin
        if (op == 8'h00 || isIllegal(op))      c = CLS_NOP;
        else if (op == OP_RET)                 c = CLS_RET;
        else if (op == OP_RETSKIP)             c = CLS_RETSKIP;
        else if (op[7:5] == 3'b000 || op[7:2] == 6'h0C || op[7:4] == 4'h4)
                                               c = CLS_SINGLE;
        else                                   c = CLS_GROUP;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mcuSeqCtrl.sv
module mcuSeqCtrl
  import mcuSeqPkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              skipReq,
  input  logic              twoByteRaw,
  input  logic              curRetSkip,
  output seqStrobe_t        str,
  output logic [STEP_W-1:0] stepCount
);

  typedef enum logic {ST_OP, ST_ARG} phase_t;

  phase_t phase;
  logic   skipFlag;
  logic   skipEff;

  assign skipEff = skipFlag | skipReq;

  always_comb begin
    str.argPhase = (phase == ST_ARG);
    str.opLoad   = (phase == ST_OP);
    str.complete = (phase == ST_ARG) || !twoByteRaw;
    str.issue    = str.complete && !skipEff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= ST_OP;
      skipFlag  <= 1'b0;
      stepCount <= '0;
    end else begin
      phase     <= (phase == ST_OP && twoByteRaw) ? ST_ARG : ST_OP;
      // a completing instruction consumes any pending skip
      skipFlag  <= str.complete ? (str.issue && curRetSkip) : skipEff;
      stepCount <= stepCount + 1'b1;
    end
  end

  // R3: operand phase always lasts exactly one step
  assert_arg_then_op_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_ARG) |=> (phase == ST_OP));

  // R4: a dropped instruction leaves no skip pending
  assert_skip_consumed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (str.complete && !str.issue) |=> !skipFlag);

  // R12: one step per cycle
  assert_step_count_R12: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (stepCount == $past(stepCount) + 1'b1));

endmodule

// File: rtl/mcuSeqPath.sv
module mcuSeqPath
  import mcuSeqPkg::*;
#(
  parameter int PC_W   = 11,
  parameter int FAMILY = FAMILY_FULL
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      str,
  input  logic [7:0]      romData,
  output logic [PC_W-1:0] romAddr,
  output logic            twoByteRaw,
  output logic            curRetSkip,
  output logic            issueValid,
  output logic [7:0]      issueOp,
  output logic [7:0]      issueArg,
  output opClass_t        issueClass,
  output logic            issueAccLoad,
  output logic            issueIllegal,
  output logic            issueWarn,
  output logic            intEnable
);

  localparam bit REDUCED = (FAMILY != FAMILY_FULL);

  logic [PC_W-1:0] pc;
  logic [7:0]      opReg;
  logic [7:0]      lastOp;
  logic [7:0]      curOp;
  logic [7:0]      curArg;
  logic            curSuppress;
  logic            curIllegal;

  assign romAddr     = pc;
  assign curOp       = str.argPhase ? opReg : romData;
  assign curArg      = str.argPhase ? romData : 8'h00;
  assign twoByteRaw  = isTwoByte(romData);
  assign curRetSkip  = (curOp == OP_RETSKIP);
  assign curIllegal  = isIllegal(curOp);
  assign curSuppress = REDUCED && isExtended(curOp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc           <= '0;
      opReg        <= 8'h00;
      lastOp       <= 8'h00;
      issueValid   <= 1'b0;
      issueOp      <= 8'h00;
      issueArg     <= 8'h00;
      issueClass   <= CLS_NOP;
      issueAccLoad <= 1'b0;
      issueIllegal <= 1'b0;
      issueWarn    <= 1'b0;
      intEnable    <= 1'b1;
    end else begin
      pc         <= pc + 1'b1;
      issueValid <= str.issue;
      if (str.opLoad)   opReg  <= romData;
      if (str.complete) lastOp <= curOp;
      if (str.issue) begin
        issueOp      <= curOp;
        issueArg     <= curArg;
        issueClass   <= (curSuppress || curIllegal) ? CLS_NOP : baseClass(curOp);
        issueAccLoad <= (curOp[7:4] == 4'h9) && (lastOp[7:4] != 4'h9);
        issueIllegal <= curIllegal;
        issueWarn    <= curSuppress;
        if (!curSuppress) begin
          if (curOp == OP_INT_ON)       intEnable <= 1'b1;
          else if (curOp == OP_INT_OFF) intEnable <= 1'b0;
        end
      end
    end
  end

  // R2: one byte consumed per cycle, counter wraps
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (pc == $past(pc) + 1'b1));

  // R10: a warned opcode never reaches a real handler
  assert_warn_is_nop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueWarn) |-> (issueClass == CLS_NOP));

  // R9: an undefined opcode never reaches a real handler
  assert_illegal_is_nop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueIllegal) |-> (issueClass == CLS_NOP));

  // R10: full family never warns
  assert_full_no_warn_R10: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !REDUCED) |-> !issueWarn);

endmodule

// File: rtl/mcuFetchSeq.sv
module mcuFetchSeq
  import mcuSeqPkg::*;
#(
  parameter int PC_W   = 11,
  parameter int STEP_W = 16,
  parameter int FAMILY = FAMILY_FULL
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [PC_W-1:0]   romAddr,
  input  logic [7:0]        romData,
  input  logic              skipReq,
  output logic              issueValid,
  output logic [7:0]        issueOp,
  output logic [7:0]        issueArg,
  output logic [3:0]        issueClass,
  output logic              issueAccLoad,
  output logic              issueIllegal,
  output logic              issueWarn,
  output logic              intEnable,
  output logic [STEP_W-1:0] stepCount
);

  seqStrobe_t str;
  logic       twoByteRaw;
  logic       curRetSkip;
  opClass_t   classReg;

  assign issueClass = classReg;

  mcuSeqCtrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .skipReq   (skipReq),
    .twoByteRaw(twoByteRaw),
    .curRetSkip(curRetSkip),
    .str       (str),
    .stepCount (stepCount)
  );

  mcuSeqPath #(.PC_W(PC_W), .FAMILY(FAMILY)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .str         (str),
    .romData     (romData),
    .romAddr     (romAddr),
    .twoByteRaw  (twoByteRaw),
    .curRetSkip  (curRetSkip),
    .issueValid  (issueValid),
    .issueOp     (issueOp),
    .issueArg    (issueArg),
    .issueClass  (classReg),
    .issueAccLoad(issueAccLoad),
    .issueIllegal(issueIllegal),
    .issueWarn   (issueWarn),
    .intEnable   (intEnable)
  );

endmodule

// File: tb/mcuFetchSeq_bench.sv
module mcuFetchSeq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PCW        = 11;
  localparam int ROMN       = 2048;
  localparam int SW         = 16;

  typedef struct {
    int         cyc;
    logic [7:0] op;
    logic [7:0] arg;
    logic [3:0] cls;
    bit         acc;
    bit         ill;
    bit         warn;
    bit         ie;
  } expItem_t;

  expItem_t qF[$];
  expItem_t qL[$];
  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;
  int  endCyc;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] rom [ROMN];

  // full-family instance
  logic [PCW-1:0] romAddrF;
  logic [7:0]     romDataF, issueOpF, issueArgF;
  logic [3:0]     issueClassF;
  logic           skipReqF, issueValidF, issueAccLoadF, issueIllegalF, issueWarnF, intEnableF;
  logic [SW-1:0]  stepCountF;
  // reduced-family instance
  logic [PCW-1:0] romAddrL;
  logic [7:0]     romDataL, issueOpL, issueArgL;
  logic [3:0]     issueClassL;
  logic           skipReqL, issueValidL, issueAccLoadL, issueIllegalL, issueWarnL, intEnableL;
  logic [SW-1:0]  stepCountL;

  assign romDataF = rom[romAddrF];
  assign romDataL = rom[romAddrL];

  mcuFetchSeq #(.PC_W(PCW), .STEP_W(SW), .FAMILY(0)) u_mcuFetchSeq (
    .clk(clk), .rstN(rstN), .romAddr(romAddrF), .romData(romDataF), .skipReq(skipReqF),
    .issueValid(issueValidF), .issueOp(issueOpF), .issueArg(issueArgF),
    .issueClass(issueClassF), .issueAccLoad(issueAccLoadF), .issueIllegal(issueIllegalF),
    .issueWarn(issueWarnF), .intEnable(intEnableF), .stepCount(stepCountF));

  mcuFetchSeq #(.PC_W(PCW), .STEP_W(SW), .FAMILY(1)) u_mcuFetchSeqLite (
    .clk(clk), .rstN(rstN), .romAddr(romAddrL), .romData(romDataL), .skipReq(skipReqL),
    .issueValid(issueValidL), .issueOp(issueOpL), .issueArg(issueArgL),
    .issueClass(issueClassL), .issueAccLoad(issueAccLoadL), .issueIllegal(issueIllegalL),
    .issueWarn(issueWarnL), .intEnable(intEnableL), .stepCount(stepCountL));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // bench-side decode, written from the requirements
  function automatic bit bTwo(input logic [7:0] op);                 // R3
    return (op >= 8'h14 && op <= 8'h17) || (op >= 8'hA0 && op <= 8'hAF) || op == 8'h1E;
  endfunction

  function automatic bit bExt(input logic [7:0] op);                 // R10
    if (op inside {8'h01, 8'h05, 8'h14, 8'h1A, 8'h1D, 8'h1F, 8'h30, 8'h31,
                   8'h42, 8'h43, 8'h46, 8'h47}) return 1;
    if (op >= 8'h4A && op <= 8'h4F) return 1;
    if ((op >= 8'h20 && op <= 8'h23) || (op >= 8'h5C && op <= 8'h5F) ||
        (op >= 8'h6C && op <= 8'h6F) || (op >= 8'h7C && op <= 8'h7F)) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] bClass(input logic [7:0] op);       // R6 R7
    if (op >= 8'hC0) return 4'd5;
    if (op >= 8'hB0) return 4'd4;
    if (op >= 8'hA0) return 4'd3;
    if (op >= 8'h90) return 4'd2;
    if (op >= 8'h80) return 4'd1;
    if (op == 8'h00 || op == 8'h1C || op == 8'h45) return 4'd0;
    if (op == 8'h48) return 4'd6;
    if (op == 8'h49) return 4'd7;
    if (op <= 8'h1F || (op >= 8'h30 && op <= 8'h33) || (op >= 8'h40 && op <= 8'h4F)) return 4'd8;
    return 4'd9;
  endfunction

  // driver: walk the program and queue the expected issues
  task automatic buildModel(input int fam);
    int pc = 0;
    int bytes = 0;
    bit skip = 0;
    bit ie = 1;
    bit sup;
    logic [7:0] last = 8'h00;
    logic [7:0] op, arg;
    expItem_t it;
    while (bytes < ROMN + 40) begin
      op = rom[pc]; pc = (pc + 1) % ROMN; bytes++; arg = 8'h00;
      if (bTwo(op)) begin arg = rom[pc]; pc = (pc + 1) % ROMN; bytes++; end
      if (skip) skip = 0;
      else begin
        sup     = (fam != 0) && bExt(op);
        it.cyc  = bytes;
        it.op   = op;
        it.arg  = arg;
        it.ill  = (op == 8'h1C) || (op == 8'h45);
        it.warn = sup;
        it.cls  = (sup || it.ill) ? 4'd0 : bClass(op);
        it.acc  = (op[7:4] == 4'h9) && (last[7:4] != 4'h9);
        if (!sup) begin
          if (op == 8'h01) ie = 0;
          if (op == 8'h31) ie = 1;
        end
        it.ie   = ie;
        skip    = (op == 8'h49) || (op == 8'h04);  // 04: bench execute stage requests skip
        if (fam == 0) qF.push_back(it); else qL.push_back(it);
      end
      last = op;
    end
  endtask

  // monitor: pop and compare
  task automatic watchOne(input int fam, input int cyc, input logic v,
                          input logic [7:0] op, input logic [7:0] arg, input logic [3:0] cls,
                          input logic acc, input logic ill, input logic warn, input logic ie);
    expItem_t e;
    bit have;
    have = (fam == 0) ? (qF.size() > 0) : (qL.size() > 0);
    if (have) begin
      if (fam == 0) e = qF[0]; else e = qL[0];
    end
    if (v) begin
      if (!have) chk(0, "R4", "unexpected issue op", op, 0);
      else begin
        if (fam == 0) void'(qF.pop_front()); else void'(qL.pop_front());
        chk(cyc == e.cyc, "R3/R4/R5", "issue cycle", cyc, e.cyc);
        chk(op == e.op,   "R3/R4/R5", "issue opcode", op, e.op);
        chk(arg == e.arg, "R3", "operand", arg, e.arg);
        chk(cls == e.cls, "R6/R7", "class", cls, e.cls);
        chk(acc == e.acc, "R8", "acc load", acc, e.acc);
        chk(ill == e.ill, "R9", "illegal", ill, e.ill);
        chk(warn == e.warn, "R10", "warn", warn, e.warn);
        chk(ie == e.ie,   "R11", "int enable", ie, e.ie);
      end
    end else if (have && e.cyc == cyc) begin
      chk(0, "R4", "missing issue at cycle", cyc, e.cyc);
      if (fam == 0) void'(qF.pop_front()); else void'(qL.pop_front());
    end
  endtask

  initial begin
    for (int i = 0; i < ROMN; i++) rom[i] = 8'h00;
    rom[0]  = 8'h00; rom[1]  = 8'h92; rom[2]  = 8'h97; rom[3]  = 8'h85;
    rom[4]  = 8'h94; rom[5]  = 8'h1C; rom[6]  = 8'h45; rom[7]  = 8'h04;
    rom[8]  = 8'h93; rom[9]  = 8'h95; rom[10] = 8'h04; rom[11] = 8'hA1;
    rom[12] = 8'h23; rom[13] = 8'h01; rom[14] = 8'h14; rom[15] = 8'h3C;
    rom[16] = 8'h49; rom[17] = 8'h1E; rom[18] = 8'h55; rom[19] = 8'h31;
    rom[20] = 8'h17; rom[21] = 8'h6A; rom[22] = 8'hB3; rom[23] = 8'hC7;
    rom[24] = 8'hF0; rom[25] = 8'h48; rom[26] = 8'h20; rom[27] = 8'h3A;
    rom[28] = 8'h0D; rom[29] = 8'h4B; rom[30] = 8'h7D; rom[31] = 8'h18;
    rom[32] = 8'hA9; rom[33] = 8'hFF; rom[34] = 8'h97; rom[35] = 8'h04;
    rom[36] = 8'h49; rom[37] = 8'h02;
    rom[ROMN-1] = 8'h14;  // operand wraps to address 0
    buildModel(0);
    buildModel(1);
    endCyc = qF[$].cyc;
    if (qL[$].cyc > endCyc) endCyc = qL[$].cyc;
    skipReqF = 1'b0;
    skipReqL = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(romAddrF == 0, "R1", "reset address", romAddrF, 0);
    chk(issueValidF == 0, "R1", "reset issue", issueValidF, 0);
    chk(intEnableF == 1, "R1", "reset int enable", intEnableF, 1);
    chk(stepCountF == 0, "R1", "reset step count", stepCountF, 0);
    chk(intEnableL == 1, "R1", "reset int enable lite", intEnableL, 1);
    rstN = 1'b1;
    for (int cyc = 1; cyc <= endCyc; cyc++) begin
      @(negedge clk);
      chk(romAddrF == PCW'(cyc % ROMN), "R2", "address", romAddrF, cyc % ROMN);
      chk(romAddrL == PCW'(cyc % ROMN), "R2", "address lite", romAddrL, cyc % ROMN);
      chk(stepCountF == SW'(cyc), "R12", "step count", stepCountF, cyc);
      watchOne(0, cyc, issueValidF, issueOpF, issueArgF, issueClassF,
               issueAccLoadF, issueIllegalF, issueWarnF, intEnableF);
      watchOne(1, cyc, issueValidL, issueOpL, issueArgL, issueClassL,
               issueAccLoadL, issueIllegalL, issueWarnL, intEnableL);
      skipReqF = issueValidF && (issueOpF == 8'h04);
      skipReqL = issueValidL && (issueOpL == 8'h04);
    end
    chk(qF.size() == 0, "R4", "unissued items", qF.size(), 0);
    chk(qL.size() == 0, "R4", "unissued items lite", qL.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule